// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive byte path of a network MAC and decides, from the first six bytes of a frame, whether the frame is meant for this station. A start-of-frame strobe opens a six-byte window. The bytes in that window form the destination address. The block handles four cases in one pass:

- an exact 48-bit match against the programmed station address;
- detection of the all-ones broadcast address;
- a multicast test through a 64-entry hash table indexed by a CRC-derived value;
- a promiscuous override.

The verdict and the address class are registered and held until the next frame starts or a clear is issued.

The byte input is a valid/ready stream. `in_ready` is held high at all times, so the filter never applies back-pressure. A byte transfers on every cycle where `in_valid` is high. Idle cycles between bytes are allowed. Bytes that fall outside an open window transfer normally but are discarded.

Top module: `addr_filter`

## Requirements
- R1: After reset, or in the cycle after `clear` is high, `dec_valid` is 0, `in_ready` is 1, and no window is open. Bytes that arrive before the next `sof` do not produce a decision.
- R2: A high `sof` opens a window. The next six transferred bytes are the address; when `in_valid` is high together with `sof`, that byte is the first one. Bytes after the sixth do not change the held decision.
- R3: `dec_valid` is 0 until the sixth address byte has transferred. It becomes 1 in the cycle after that transfer, and `dec_accept`/`dec_kind` then stay constant until `sof` or `clear`.
- R4: Address byte k (k = 0..5, in arrival order) is compared with `station_addr[8k+7:8k]`. The group bit is bit 0 of byte 0.
- R5: If the group bit is 0, `dec_kind` = 0 (individual). The frame is accepted only when `en_phys` is 1 and all 48 bits equal `station_addr`; a difference in any one byte rejects it.
- R6: If the group bit is 1 and the address is not all ones, `dec_kind` = 1 (group). The hash index is taken from the CRC register after the six bytes, using these settings:
  - register preset to all ones;
  - each byte shifted in LSB first;
  - reflected polynomial 0xEDB88320;
  - no final inversion.

  The index is bits 31:26 of that register. The frame is accepted only when `en_mcast` is 1 and `hash_table[index]` is 1.
- R7: If all 48 address bits are 1, `dec_kind` = 2 (broadcast). The frame is accepted exactly when `en_bcast` is 1, whatever the hash table holds.
- R8: When `en_promisc` is 1 at the sixth byte, `dec_accept` is 1 for any address, and `dec_kind` still reports the class.
- R9: A `sof` pulse after a decision clears `dec_valid` from the next cycle.
- R10: Cycles with `in_valid` low inside the window do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of window and decision |
| sof | input | 1 | Start-of-frame strobe, opens the address window |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready, always 1 |
| in_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_table | input | 64 | Group hash table, bit i for index i |
| en_phys | input | 1 | Accept individual addresses that match |
| en_mcast | input | 1 | Accept group addresses that hit in the hash table |
| en_bcast | input | 1 | Accept the broadcast address |
| en_promisc | input | 1 | Accept every frame |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 2 | 0 individual, 1 group, 2 broadcast |

## Verification
The hardest case to reach is a group address whose hash bit lies in one particular table position. The bench runs the six bytes through its own bit-serial CRC model to find the index. It then programs a table with only that bit set for a hit, and its complement for a miss, so the outcome depends on the index being exactly right. Stray bytes are sent after a clear, and extra bytes after the sixth; the decision must not move in either case. One frame is sent with the start strobe on the same cycle as its first byte, to catch off-by-one window errors.

// File: rtl/afd_pkg.sv
package afd_pkg;

  typedef enum logic [1:0] {
    KIND_PHYS  = 2'd0,
    KIND_MCAST = 2'd1,
    KIND_BCAST = 2'd2
  } addr_kind_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // one byte through the reflected CRC register, LSB of the byte first
  function automatic logic [31:0] crc_feed_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/afd_seq.sv
module afd_seq #(
  parameter int ADDR_BYTES = 6,
  localparam int CW = $clog2(ADDR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sof,
  input  logic          in_valid,
  output logic          take,
  output logic          last_take,
  output logic [CW-1:0] idx
);
  localparam logic [CW-1:0] LIM = CW'(ADDR_BYTES);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;

  assign base      = sof ? '0 : cnt;
  assign idx       = base;
  assign take      = in_valid && (base < LIM);
  assign last_take = take && (base == LIM - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= LIM;
    else if (clear)  cnt <= LIM;
    else if (take)   cnt <= base + 1'b1;
    else             cnt <= base;
  end

  // window counter never runs past the address length
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  // after a clear no window is open
  assert_clear_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == LIM));

endmodule

// File: rtl/afd_crc.sv
module afd_crc #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 restart,
  input  logic                 take,
  input  logic [7:0]           data,
  output logic [HASH_BITS-1:0] hash_idx
);
  import afd_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_nxt;

  assign crc_base = restart ? 32'hFFFF_FFFF : crc_q;
  assign crc_nxt  = take ? crc_feed_byte(crc_base, data) : crc_base;
  assign hash_idx = crc_nxt[31 -: HASH_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= 32'hFFFF_FFFF;
    else if (clear) crc_q <= 32'hFFFF_FFFF;
    else            crc_q <= crc_nxt;
  end

  // a new frame always starts from the preset value
  assert_crc_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !take && !clear) |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/afd_cmp.sv
module afd_cmp #(
  parameter int ADDR_BYTES = 6,
  localparam int CW = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    restart,
  input  logic                    take,
  input  logic [CW-1:0]           idx,
  input  logic [7:0]              data,
  input  logic [ADDR_BYTES*8-1:0] station_addr,
  output logic                    eq_nxt,
  output logic                    ones_nxt,
  output logic                    grp_nxt
);
  logic [7:0] st_byte [ADDR_BYTES];
  logic       eq_q, ones_q, grp_q;
  logic       eq_b, ones_b, grp_b;
  logic [7:0] ref_byte;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
    assign st_byte[g] = station_addr[g*8 +: 8];
  end

  assign ref_byte = (idx < CW'(ADDR_BYTES)) ? st_byte[idx] : 8'h00;

  assign eq_b   = restart ? 1'b1 : eq_q;
  assign ones_b = restart ? 1'b1 : ones_q;
  assign grp_b  = restart ? 1'b0 : grp_q;

  assign eq_nxt   = take ? (eq_b && (data == ref_byte)) : eq_b;
  assign ones_nxt = take ? (ones_b && (data == 8'hFF)) : ones_b;
  assign grp_nxt  = (take && idx == '0) ? data[0] : grp_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      eq_q   <= 1'b1;
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
    end else begin
      eq_q   <= eq_nxt;
      ones_q <= ones_nxt;
      grp_q  <= grp_nxt;
    end
  end

  // a mismatch, once seen, persists until the next frame starts
  assert_mismatch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!eq_q && !restart && !clear) |=> !eq_q);

endmodule

// File: rtl/addr_filter.sv
module addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int CW        = $clog2(ADDR_BYTES + 1),
  localparam int AW        = ADDR_BYTES * 8,
  localparam int TW        = 1 << HASH_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sof,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] station_addr,
  input  logic [TW-1:0] hash_table,
  input  logic          en_phys,
  input  logic          en_mcast,
  input  logic          en_bcast,
  input  logic          en_promisc,
  output logic          dec_valid,
  output logic          dec_accept,
  output logic [1:0]    dec_kind
);
  import afd_pkg::*;

  logic                 take, last_take;
  logic [CW-1:0]        idx;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 eq_nxt, ones_nxt, grp_nxt;
  addr_kind_e           kind_d, kind_q;
  logic                 acc_d, acc_q, val_q;

  assign in_ready = 1'b1;

  afd_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sof(sof), .in_valid(in_valid),
    .take(take), .last_take(last_take), .idx(idx)
  );

  afd_crc #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .restart(sof), .take(take),
    .data(in_data), .hash_idx(hash_idx)
  );

  afd_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(clear), .restart(sof), .take(take), .idx(idx),
    .data(in_data), .station_addr(station_addr),
    .eq_nxt(eq_nxt), .ones_nxt(ones_nxt), .grp_nxt(grp_nxt)
  );

  always_comb begin
    if (ones_nxt) begin
      kind_d = KIND_BCAST;
      acc_d  = en_bcast;
    end else if (grp_nxt) begin
      kind_d = KIND_MCAST;
      acc_d  = en_mcast && hash_table[hash_idx];
    end else begin
      kind_d = KIND_PHYS;
      acc_d  = en_phys && eq_nxt;
    end
    acc_d = acc_d || en_promisc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0; acc_q <= 1'b0; kind_q <= KIND_PHYS;
    end else if (clear) begin
      val_q <= 1'b0; acc_q <= 1'b0; kind_q <= KIND_PHYS;
    end else if (last_take) begin
      val_q <= 1'b1; acc_q <= acc_d; kind_q <= kind_d;
    end else if (sof) begin
      val_q <= 1'b0;
    end
  end

  assign dec_valid  = val_q;
  assign dec_accept = acc_q;
  assign dec_kind   = kind_q;

  assert_valid_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(last_take));

  assert_decision_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(dec_valid) && !$past(sof) && !$past(clear))
      |-> ($stable(dec_accept) && $stable(dec_kind)));

  assert_sof_drops_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !last_take && !clear) |=> !dec_valid);

  assert_clear_drops_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !dec_valid);

  assert_promisc_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(en_promisc)) |-> dec_accept);

  assert_kind_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_kind != 2'd3));

endmodule

// File: tb/addr_filter_test.sv
module addr_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        sof = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [47:0] station_addr = 48'h5A4C_3E2B_1A02;
  logic [63:0] hash_table = 64'h0;
  logic        en_phys = 1'b0, en_mcast = 1'b0, en_bcast = 1'b0, en_promisc = 1'b0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_kind;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  addr_filter uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sof(sof), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .station_addr(station_addr),
    .hash_table(hash_table), .en_phys(en_phys), .en_mcast(en_mcast),
    .en_bcast(en_bcast), .en_promisc(en_promisc), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_kind(dec_kind)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] model_hash(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic        fb;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ da[8*k + b];
        c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
      end
    return c[31:26];
  endfunction

  // called at a negedge; leaves at the negedge after the sixth byte's edge
  task automatic send_frame(input logic [47:0] da, input int gap, input bit joint);
    if (!joint) begin
      sof = 1'b1;
      @(posedge clk); @(negedge clk);
      sof = 1'b0;
    end
    for (int k = 0; k < 6; k++) begin
      if (k == 5) check(dec_valid == 1'b0, "R3", "valid before sixth byte", dec_valid, 0);
      in_valid = 1'b1;
      in_data  = da[8*k +: 8];
      if (joint && k == 0) sof = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      sof      = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic expect_dec(input string req, input bit acc, input logic [1:0] kind);
    check(dec_valid == 1'b1, req, "dec_valid", dec_valid, 1);
    check(dec_accept == acc, req, "dec_accept", dec_accept, acc);
    check(dec_kind == kind, req, "dec_kind", dec_kind, kind);
  endtask

  task automatic set_modes(input bit p, input bit m, input bit b, input bit q);
    en_phys = p; en_mcast = m; en_bcast = b; en_promisc = q;
  endtask

  task automatic t_reset;
    check(dec_valid == 1'b0, "R1", "valid after reset", dec_valid, 0);
    check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    in_valid = 1'b1; in_data = 8'h02;
    repeat (8) @(negedge clk);
    in_valid = 1'b0;
    check(dec_valid == 1'b0, "R1", "stray bytes gave decision", dec_valid, 0);
  endtask

  task automatic t_phys;
    set_modes(1, 0, 0, 0);
    send_frame(station_addr, 0, 0);
    expect_dec("R5", 1'b1, 2'd0);
    send_frame(station_addr ^ 48'h0100_0000_0000, 0, 0);
    expect_dec("R5", 1'b0, 2'd0);
    send_frame(station_addr ^ 48'h0000_0000_8000, 0, 0);
    expect_dec("R5", 1'b0, 2'd0);
    send_frame(48'h021A_2B3E_4C5A, 0, 0);
    expect_dec("R4", 1'b0, 2'd0);
    set_modes(0, 1, 1, 0);
    send_frame(station_addr, 0, 0);
    expect_dec("R5", 1'b0, 2'd0);
  endtask

  task automatic t_mcast;
    logic [47:0] da = 48'h0100_005E_0001;
    logic [5:0]  hi = model_hash(48'h0100_005E_0001);
    set_modes(0, 1, 0, 0);
    hash_table = 64'h1 << hi;
    send_frame(da, 0, 0);
    expect_dec("R6", 1'b1, 2'd1);
    hash_table = ~(64'h1 << hi);
    send_frame(da, 0, 0);
    expect_dec("R6", 1'b0, 2'd1);
    hash_table = 64'h1 << hi;
    set_modes(1, 0, 1, 0);
    send_frame(da, 0, 0);
    expect_dec("R6", 1'b0, 2'd1);
  endtask

  task automatic t_bcast;
    set_modes(0, 1, 1, 0);
    hash_table = 64'h0;
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0);
    expect_dec("R7", 1'b1, 2'd2);
    set_modes(1, 1, 0, 0);
    hash_table = {64{1'b1}};
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0);
    expect_dec("R7", 1'b0, 2'd2);
  endtask

  task automatic t_promisc;
    set_modes(0, 0, 0, 1);
    hash_table = 64'h0;
    send_frame(48'h1234_5678_9A00, 0, 0);
    expect_dec("R8", 1'b1, 2'd0);
    send_frame(48'h1234_5678_9A03, 0, 0);
    expect_dec("R8", 1'b1, 2'd1);
  endtask

  task automatic t_window;
    set_modes(1, 0, 0, 0);
    send_frame(station_addr, 0, 1);
    expect_dec("R2", 1'b1, 2'd0);
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    expect_dec("R2", 1'b1, 2'd0);
    send_frame(station_addr, 3, 0);
    expect_dec("R10", 1'b1, 2'd0);
  endtask

  task automatic t_restart;
    set_modes(1, 0, 0, 0);
    send_frame(station_addr, 0, 0);
    sof = 1'b1;
    @(posedge clk); @(negedge clk);
    sof = 1'b0;
    check(dec_valid == 1'b0, "R9", "valid after new sof", dec_valid, 0);
    send_frame(station_addr, 0, 0);
    clear = 1'b1;
    @(posedge clk); @(negedge clk);
    clear = 1'b0;
    check(dec_valid == 1'b0, "R1", "valid after clear", dec_valid, 0);
    in_valid = 1'b1; in_data = 8'h02;
    repeat (7) @(negedge clk);
    in_valid = 1'b0;
    check(dec_valid == 1'b0, "R1", "bytes after clear without sof", dec_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_phys();
    t_mcast();
    t_bcast();
    t_promisc();
    t_window();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule